// File: doc/BRIEF.md
# Peripheral Bus Master with Retry

This block turns single read and write requests from a processor core into cycles on a 16-bit peripheral bus. Each request carries an address, write data, an access size (byte or halfword) and a read-modify-write flag. A cycle drives the low 14 address bits, the write data, a write indicator and an active-low upper-byte enable. It then pulses a data strobe. Read data comes back on a separate input bus and is captured when the strobe falls. A data-output-enable follows the write indicator, so it can drive the enable of an external tri-state buffer on a shared data line.

A peripheral can ask for a cycle to be repeated by raising retry at the strobe's falling edge. An external decoder then qualifies that request with a retry-enable input. A retried cycle keeps every bus output unchanged, waits one idle clock and strobes again. The core only sees the result of the attempt that completes without retry.

A read issued with the read-modify-write flag raises a lock output. The lock stays high through the following write, so that interrupt flag updates can be held off for the whole sequence.

The request side is valid/ready. `req_ready` is high only while the master is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A core that sees `req_ready` low keeps `req_valid` and its fields steady. The response side has no back-pressure: `rsp_valid` is a single-clock pulse that the core must take when it appears.

Top module: `pbus_master`

## Requirements
- R1: After reset, `pb_stb`, `pb_wr`, `pb_doe`, `pb_lock` and `rsp_valid` are low and `req_ready` is high.
- R2: Taking a request is followed by one clock with the strobe low (address setup) and then exactly two clocks with `pb_stb` high. The strobe then falls.
- R3: From the setup clock until the cycle completes, `pb_addr` equals bits 13:0 of the request address and `pb_wdata` equals the request write data, and both are held steady.
- R4: `pb_wr` and `pb_doe` are high on every clock of a write cycle, from setup through the strobe fall. Both are low on every clock of a read cycle.
- R5: `pb_ube_n` is 0 for a halfword access (`req_size`=1) and for a byte access (`req_size`=0) with address bit 0 = 1. It is 1 for a byte access with address bit 0 = 0.
- R6: On the clock after the strobe falls without retry, `rsp_valid` is high for exactly one clock. For a read, `rsp_rdata` then holds the `pb_rdata` value present just before that fall.
- R7: If `pb_retry` and `pb_retry_en` are both high at the strobe's falling edge, the strobe stays low for one clock and then runs another two-clock pulse. During this, address, write data, write indicator and byte enable are unchanged and `rsp_valid` stays low.
- R8: If `pb_retry_en` is low, a high `pb_retry` has no effect: the cycle ends after a single strobe pulse and is acknowledged.
- R9: A read taken with `req_rmw`=1 raises `pb_lock` from its setup clock. The lock stays high until the clock after the next write is acknowledged, and then it is low.
- R10: `req_ready` is low on every clock from setup until the strobe of the completing attempt falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Master idle, request accepted this edge if valid |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_size | input | 1 | 1 = halfword, 0 = byte |
| req_rmw | input | 1 | Read belongs to a read-modify-write sequence |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data returned with `rsp_valid` |
| pb_addr | output | 14 | Bus address, low bits of the access address |
| pb_wdata | output | 16 | Bus write data |
| pb_rdata | input | 16 | Bus read data |
| pb_wr | output | 1 | High through a write cycle |
| pb_stb | output | 1 | Data strobe |
| pb_lock | output | 1 | Bus lock for read-modify-write |
| pb_ube_n | output | 1 | Upper byte enable, active low |
| pb_retry | input | 1 | Peripheral retry request |
| pb_retry_en | input | 1 | Decoder qualification of retry |
| pb_doe | output | 1 | Data-output-enable for external tri-state buffer |

## Verification
If a request is taken at edge E0, the setup state shows on the clock after E0. The strobe is high on the two clocks after edges E1 and E2, and the completion pulse follows edge E3. Each retry adds three clocks: one idle clock and two strobe clocks. The driver presents each request just after a falling edge and then walks falling edges one at a time, comparing every bus pin there against the slot it expects for that clock. Every result is therefore sampled half a clock after the register that produces it. A scoreboard queue holds the expected read data and pops one entry on each `rsp_valid` pulse. The bench's read data includes the index of the current strobe pulse, so a capture from the wrong attempt shows up as a mismatch.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_STB1  = 3'd2,
    S_STB2  = 3'd3,
    S_GAP   = 3'd4
  } seq_st_t;
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          retry,
  input  logic          retry_en,
  input  logic [DW-1:0] bus_rdata,
  output logic          idle,
  output logic          stb,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  seq_st_t st_q;
  logic    retry_take;

  assign retry_take = retry && retry_en;
  assign idle = (st_q == S_IDLE);
  assign stb  = (st_q == S_STB1) || (st_q == S_STB2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        S_IDLE:  if (start) st_q <= S_SETUP;
        S_SETUP: st_q <= S_STB1;
        S_STB1:  st_q <= S_STB2;
        S_STB2: begin
          if (retry_take) begin
            st_q <= S_GAP;
          end else begin
            st_q      <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= bus_rdata;
          end
        end
        S_GAP:   st_q <= S_STB1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R2: strobe pulse lasts exactly two clocks
  a_r2_stb_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |=> stb);
  a_r2_stb_max: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(stb)) |=> !stb);
  // R6: acknowledge only right after a strobe fall
  a_r6_ack_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(stb) && !stb));
  // R7: a qualified retry at the fall suppresses acknowledge
  a_r7_no_ack_on_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(stb) && retry && retry_en) |=> (!rsp_valid && !stb));
  // R10: no new start while busy
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |-> 1'b0);
endmodule

// File: rtl/pbus_hold.sv
module pbus_hold #(
  parameter int AW     = 32,
  parameter int BUS_AW = 14,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic [AW-1:0]     in_addr,
  input  logic [DW-1:0]     in_wdata,
  input  logic              in_write,
  input  logic              in_half,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_wr,
  output logic              bus_doe,
  output logic              bus_ube_n,
  output logic              wr_q
);
  logic ube_n_d;

  // upper byte used by halfwords and by odd byte addresses
  assign ube_n_d = !(in_half || in_addr[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      wr_q      <= 1'b0;
      bus_ube_n <= 1'b1;
    end else if (start) begin
      bus_addr  <= in_addr[BUS_AW-1:0];
      bus_wdata <= in_wdata;
      wr_q      <= in_write;
      bus_ube_n <= ube_n_d;
    end
  end

  assign bus_wr  = wr_q && busy;
  assign bus_doe = wr_q && busy;

  // R3/R7: bus fields stay fixed for the whole cycle including retries
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_wdata)
                              && $stable(bus_ube_n)));
  // R4: write indicator constant while busy
  a_r4_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_wr));
endmodule

// File: rtl/pbus_lock.sv
module pbus_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_write,
  input  logic in_rmw,
  input  logic ack,
  input  logic ack_was_wr,
  output logic lock
);
  logic set_lk;
  logic clr_lk;

  assign set_lk = start && !in_write && in_rmw;
  assign clr_lk = ack && ack_was_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock <= 1'b0;
    else if (set_lk) lock <= 1'b1;
    else if (clr_lk) lock <= 1'b0;
  end

  // R9: lock rises only from an accepted locked read
  a_r9_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(start && !in_write && in_rmw));
  // R9: lock falls only after a write acknowledge
  a_r9_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(ack && ack_was_wr));
endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int AW     = 32,
  parameter int BUS_AW = 14,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_size,
  input  logic              req_rmw,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [BUS_AW-1:0] pb_addr,
  output logic [DW-1:0]     pb_wdata,
  input  logic [DW-1:0]     pb_rdata,
  output logic              pb_wr,
  output logic              pb_stb,
  output logic              pb_lock,
  output logic              pb_ube_n,
  input  logic              pb_retry,
  input  logic              pb_retry_en,
  output logic              pb_doe
);
  logic idle;
  logic start;
  logic wr_q;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  pbus_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .retry     (pb_retry),
    .retry_en  (pb_retry_en),
    .bus_rdata (pb_rdata),
    .idle      (idle),
    .stb       (pb_stb),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  pbus_hold #(.AW(AW), .BUS_AW(BUS_AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (!idle),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .in_write  (req_write),
    .in_half   (req_size),
    .bus_addr  (pb_addr),
    .bus_wdata (pb_wdata),
    .bus_wr    (pb_wr),
    .bus_doe   (pb_doe),
    .bus_ube_n (pb_ube_n),
    .wr_q      (wr_q)
  );

  pbus_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_write   (req_write),
    .in_rmw     (req_rmw),
    .ack        (rsp_valid),
    .ack_was_wr (wr_q),
    .lock       (pb_lock)
  );

  // R4: output enable only during writes
  a_r4_doe_write: assert property (@(posedge clk) disable iff (!rst_n)
    pb_doe |-> pb_wr);
  // R1/R10: strobe never active while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!pb_stb && !pb_wr));
endmodule

// File: tb/pbus_master_tb.sv
`timescale 1ns/1ps
module pbus_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_size = 1'b0;
  logic        req_rmw = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [13:0] pb_addr;
  logic [15:0] pb_wdata;
  logic [15:0] pb_rdata;
  logic        pb_wr, pb_stb, pb_lock, pb_ube_n, pb_doe;
  logic        pb_retry = 1'b0;
  logic        pb_retry_en = 1'b0;
  logic [15:0] salt = '0;

  int checks = 0;
  int errors = 0;
  logic lock_exp = 1'b0;
  logic [16:0] sb_q[$];

  always #4 clk = ~clk;

  assign pb_rdata = ({2'b00, pb_addr} ^ 16'hA5C3) + salt;

  pbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_rmw(req_rmw), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata), .pb_wr(pb_wr), .pb_stb(pb_stb), .pb_lock(pb_lock),
    .pb_ube_n(pb_ube_n), .pb_retry(pb_retry), .pb_retry_en(pb_retry_en),
    .pb_doe(pb_doe)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6 unexpected response", 32'(rsp_rdata), 32'h0);
      end else begin
        logic [16:0] e;
        e = sb_q.pop_front();
        if (!e[16]) chk(rsp_rdata == e[15:0], "R6 read data", 32'(rsp_rdata), 32'(e[15:0]));
      end
    end
  end

  task automatic bus_cmp(input logic [31:0] a, input logic w, input logic [15:0] wd,
                         input logic ube, input string tag);
    chk(pb_addr == a[13:0], {tag, " R3 addr"}, 32'(pb_addr), 32'(a[13:0]));
    chk(pb_wdata == wd, {tag, " R3 wdata"}, 32'(pb_wdata), 32'(wd));
    chk(pb_wr == w && pb_doe == w, {tag, " R4 wr/doe"}, {30'd0, pb_wr, pb_doe}, {30'd0, w, w});
    chk(pb_ube_n == ube, {tag, " R5 ube_n"}, 32'(pb_ube_n), 32'(ube));
    chk(req_ready == 1'b0, {tag, " R10 ready low"}, 32'(req_ready), 32'h0);
    chk(pb_lock == lock_exp, {tag, " R9 lock"}, 32'(pb_lock), 32'(lock_exp));
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [15:0] wd,
                        input logic half, input logic rmw, input int nretry,
                        input logic en);
    int pulses;
    logic ube;
    ube = !(half || a[0]);
    pulses = en ? nretry + 1 : 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd;
    req_size = half; req_rmw = rmw;
    pb_retry_en = en;
    pb_retry = (nretry > 0);
    salt = 16'd0;
    if (!w) sb_q.push_back({1'b0, (({2'b00, a[13:0]} ^ 16'hA5C3) + 16'(pulses - 1))});
    else    sb_q.push_back({1'b1, 16'h0});
    if (!w && rmw) lock_exp = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(pb_stb == 1'b0, "R2 setup strobe low", 32'(pb_stb), 32'h0);
    bus_cmp(a, w, wd, ube, "setup");
    for (int p = 0; p < pulses; p++) begin
      if (p > 0) begin
        @(negedge clk);
        chk(pb_stb == 1'b0, "R7 idle clock between pulses", 32'(pb_stb), 32'h0);
        chk(rsp_valid == 1'b0, "R7 ack withheld", 32'(rsp_valid), 32'h0);
        bus_cmp(a, w, wd, ube, "R7 gap");
        salt = 16'(p);
      end
      @(negedge clk);
      chk(pb_stb == 1'b1, "R2 strobe high 1", 32'(pb_stb), 32'h1);
      bus_cmp(a, w, wd, ube, "stb1");
      @(negedge clk);
      chk(pb_stb == 1'b1, "R2 strobe high 2", 32'(pb_stb), 32'h1);
      bus_cmp(a, w, wd, ube, "stb2");
      if (en) pb_retry = (p < nretry);
    end
    @(negedge clk);
    chk(pb_stb == 1'b0, "R2 strobe fallen", 32'(pb_stb), 32'h0);
    chk(rsp_valid == 1'b1, "R6 R8 ack pulse", 32'(rsp_valid), 32'h1);
    chk(pb_wr == 1'b0 && pb_doe == 1'b0, "R4 wr released", {30'd0, pb_wr, pb_doe}, 32'h0);
    chk(pb_lock == lock_exp, "R9 lock at ack", 32'(pb_lock), 32'(lock_exp));
    pb_retry = 1'b0;
    if (w) lock_exp = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6 ack one clock", 32'(rsp_valid), 32'h0);
    chk(pb_lock == lock_exp, "R9 lock after ack", 32'(pb_lock), 32'(lock_exp));
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pb_stb && !pb_wr && !pb_doe && !pb_lock && !rsp_valid && req_ready,
        "R1 reset state", {26'd0, pb_stb, pb_wr, pb_doe, pb_lock, rsp_valid, req_ready},
        32'h1);
    rst_n = 1'b1;
    // R5: halfword, odd byte, even byte; R3 address truncation
    access(32'h1234_5678, 1'b0, 16'h0000, 1'b1, 1'b0, 0, 1'b0);
    access(32'h0000_3FFF, 1'b0, 16'h0000, 1'b0, 1'b0, 0, 1'b0);
    access(32'hFFFF_C002, 1'b1, 16'hBEEF, 1'b0, 1'b0, 0, 1'b0);
    access(32'h0000_0ABC, 1'b1, 16'h1357, 1'b1, 1'b0, 0, 1'b1);
    // R7: qualified retries on read and write
    access(32'h0000_0246, 1'b0, 16'h0000, 1'b1, 1'b0, 2, 1'b1);
    access(32'h0000_1111, 1'b1, 16'hC0DE, 1'b0, 1'b0, 1, 1'b1);
    // R8: retry ignored without enable
    access(32'h0000_2468, 1'b0, 16'h0000, 1'b1, 1'b0, 3, 1'b0);
    // R9: locked read, unlocked read in between, then write releases lock
    access(32'h0000_0040, 1'b0, 16'h0000, 1'b1, 1'b1, 0, 1'b0);
    access(32'h0000_0080, 1'b0, 16'h0000, 1'b0, 1'b0, 0, 1'b0);
    access(32'h0000_0040, 1'b1, 16'h00FF, 1'b1, 1'b0, 1, 1'b1);
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R6 all responses seen", 32'(sb_q.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule